// File: doc/BRIEF.md
# Dual-Resolution Stochastic Pixel Tally

This block takes a 4x4 tile of sixteen pixel bitstreams that are already stochastically encoded. It accumulates them at two spatial resolutions during one frame window. Each pixel stream has its own ones-counter. A sixteen-way selector picks one stream per cycle, and its select comes from a free-running pseudo-random register that is independent of the pixel encoders. The selected bit therefore has a probability equal to the mean of the sixteen pixel probabilities. That bit feeds one extra counter, which holds the low-resolution tile value. In cost terms, the coarse image adds one counter and one multiplexer.

A single-cycle start pulse clears every counter and opens a window of a fixed number of cycles (256 by default). When the window closes, a done flag rises and the counts freeze. Every counter can be read through a combinational address port at any time, including mid-frame. Early reads give lower-precision images, and pixel addresses give finer images than the tile address.

Top module: `superpix_accum`

## Requirements
- R1: After reset, done is 0 and every address (0 to 16) reads 0.
- R2: A start pulse clears all seventeen counters and done. The window then covers the 256 rising edges that follow the edge where start is sampled.
- R3: The value at address k (0 to 15) equals the number of window edges at which pix_bits[k] was 1.
- R4: The tile counter (address 16) rises by exactly one at a window edge when all sixteen bits are 1, and holds when all are 0. It never rises by more than one per edge.
- R5: When all sixteen bits carry the same value at every window edge, the tile count equals each pixel count exactly.
- R6: For differing streams, the final tile count lies within 32 of the integer quotient of the sum of the sixteen pixel counts divided by 16.
- R7: done rises at the 256th window edge and stays high until the next start. After that edge, input bits no longer change any counter.
- R8: Addresses 0 to 15 select pixel counters, 16 selects the tile counter, and 17 to 31 read 0. The read is combinational.
- R9: A start pulse during an open window restarts the window from zero counts.
- R10: Mid-window reads return the ones counted so far (progressive precision).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the counts and opens a window |
| pix_bits | input | 16 | One stochastic bit per pixel per cycle, bit k is pixel k |
| rd_addr | input | 5 | Counter select: 0-15 pixels, 16 tile |
| rd_data | output | 9 | Current value of the selected counter |
| done | output | 1 | High once the window has closed |

## Verification
The tile count depends on the pseudo-random select sequence, which cannot be seen from the ports. Exact checks of the tile counter are therefore limited to inputs where the select has no effect: all zeros, all ones, and identical streams on all sixteen pixels. Mixed-density patterns use a tolerance band around the pixel average. The freeze after done is reached by driving all-ones after the window closes and re-reading every counter. The restart case is reached by issuing a second start partway through an all-ones window.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SP_NPIX  = 16;
    localparam int SP_CNT_W = 9;
    localparam int SP_FRAME = 256;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/sp_sel_lfsr.sv
module sp_sel_lfsr #(
    parameter int          SEL_W = 4,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] sel_o
);
    typedef struct packed {
        logic [15:0] sr;
    } lfsr_t;

    lfsr_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[14:0],
                   st_q.sr[15] ^ st_q.sr[13] ^ st_q.sr[12] ^ st_q.sr[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sr <= SEED;
        else        st_q    <= st_d;
    end

    assign sel_o = st_q.sr[SEL_W-1:0];
endmodule

// File: rtl/sp_frame_ctrl.sv
module sp_frame_ctrl
    import sp_pkg::*;
#(
    parameter int FRAME_LEN = SP_FRAME
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic run_o,
    output logic done_o
);
    localparam int CYC_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [CYC_W-1:0] cyc;
    } ctrl_t;

    ctrl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.ph  = PH_RUN;
            st_d.cyc = '0;
        end else if (st_q.ph == PH_RUN) begin
            st_d.cyc = st_q.cyc + CYC_W'(1);
            if (st_q.cyc == CYC_W'(FRAME_LEN - 1)) st_d.ph = PH_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cyc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = (st_q.ph == PH_RUN);
    assign done_o = (st_q.ph == PH_DONE);
endmodule

// File: rtl/sp_tally.sv
module sp_tally #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_t;

    tally_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i)              st_d.cnt = '0;
        else if (en_i && bit_i) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/superpix_accum.sv
module superpix_accum
    import sp_pkg::*;
#(
    parameter int NPIX      = SP_NPIX,
    parameter int CNT_W     = SP_CNT_W,
    parameter int FRAME_LEN = SP_FRAME,
    parameter int ADDR_W    = $clog2(NPIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPIX-1:0]   pix_bits,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              done
);
    localparam int SEL_W = $clog2(NPIX);

    logic                  run_w;
    logic [SEL_W-1:0]      sel_w;
    logic                  mux_bit_w;
    logic [CNT_W-1:0]      pix_cnt_w [NPIX];
    logic [CNT_W-1:0]      super_cnt_w;
    logic [NPIX*CNT_W-1:0] pix_flat_w;

    sp_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .run_o(run_w), .done_o(done)
    );

    sp_sel_lfsr #(.SEL_W(SEL_W)) sel_i (
        .clk(clk), .rst_n(rst_n), .sel_o(sel_w)
    );

    assign mux_bit_w = pix_bits[sel_w];

    for (genvar k = 0; k < NPIX; k++) begin : g_pix
        sp_tally #(.CNT_W(CNT_W)) tally_i (
            .clk(clk), .rst_n(rst_n), .clr_i(start), .en_i(run_w),
            .bit_i(pix_bits[k]), .cnt_o(pix_cnt_w[k])
        );
        assign pix_flat_w[k*CNT_W +: CNT_W] = pix_cnt_w[k];
    end

    sp_tally #(.CNT_W(CNT_W)) super_i (
        .clk(clk), .rst_n(rst_n), .clr_i(start), .en_i(run_w),
        .bit_i(mux_bit_w), .cnt_o(super_cnt_w)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NPIX))       rd_data = pix_cnt_w[rd_addr[SEL_W-1:0]];
        else if (rd_addr == ADDR_W'(NPIX)) rd_data = super_cnt_w;
    end
endmodule

// File: rtl/sp_avg_chk.sv
module sp_avg_chk #(
    parameter int NPIX  = 16,
    parameter int CNT_W = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  run,
    input logic                  done,
    input logic [NPIX-1:0]       pix_bits,
    input logic [CNT_W-1:0]      super_cnt,
    input logic [NPIX*CNT_W-1:0] pix_flat
);
    // R2: a start pulse clears every counter and done
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (super_cnt == '0 && pix_flat == '0 && !done));

    // R4: all-zero inputs leave the tile counter unchanged
    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && pix_bits == '0) |=> $stable(super_cnt));

    // R4: all-one inputs step the tile counter by exactly one
    a_r4_step_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && pix_bits == '1) |=> super_cnt == $past(super_cnt) + CNT_W'(1));

    // R4: the tile counter never rises by more than one per edge
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> (super_cnt - $past(super_cnt)) <= CNT_W'(1));

    // R7: done and an open window are mutually exclusive
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && run));

    // R7: outside a window no counter moves
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> ($stable(pix_flat) && $stable(super_cnt)));
endmodule

bind superpix_accum sp_avg_chk #(.NPIX(NPIX), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run_w), .done(done),
    .pix_bits(pix_bits), .super_cnt(super_cnt_w), .pix_flat(pix_flat_w)
);

// File: tb/superpix_accum_tb.sv
`timescale 1ns/1ps
module superpix_accum_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [15:0] pix_bits = '0;
    logic [4:0]  rd_addr = '0;
    logic [8:0]  rd_data;
    logic        done;

    int checks = 0;
    int failures = 0;
    int exp_pix [16];

    always #2.5 clk = ~clk;

    superpix_accum dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_bits(pix_bits),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 5'(a);
        #0.5;
        v = int'(rd_data);
    endtask

    function automatic bit pbit(input int pat, input int k, input int c);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return (c % 3) == 0;
            3: return ((c * 7 + k * 13) % 16) < (k + 1);
            4: return k == 5;
            default: return ((c + k) % 2) == 1;
        endcase
    endfunction

    task automatic run_frame(input int pat);
        int v;
        int sum;
        @(negedge clk);
        start = 1; pix_bits = '0;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 16; k++) exp_pix[k] = 0;
        for (int c = 0; c < 256; c++) begin
            if (c == 100) begin
                rd(3, v);
                chk(v == exp_pix[3], "R10 mid-window pixel count", v, exp_pix[3]);
            end
            if (c == 255) chk(done == 1'b0, "R7 done low inside window", int'(done), 0);
            for (int k = 0; k < 16; k++) begin
                pix_bits[k] = pbit(pat, k, c);
                if (pbit(pat, k, c)) exp_pix[k]++;
            end
            @(negedge clk);
        end
        pix_bits = '0;
        chk(done == 1'b1, "R7 done after window", int'(done), 1);
        sum = 0;
        for (int k = 0; k < 16; k++) begin
            rd(k, v);
            chk(v == exp_pix[k], "R3 pixel count", v, exp_pix[k]);
            sum += exp_pix[k];
        end
        rd(16, v);
        if (pat == 0)      chk(v == 0, "R4 tile all zero", v, 0);
        else if (pat == 1) chk(v == 256, "R4 tile all one", v, 256);
        else if (pat == 2) chk(v == exp_pix[0], "R5 identical streams", v, exp_pix[0]);
        else chk((v - sum / 16 <= 32) && (sum / 16 - v <= 32), "R6 tile within band", v, sum / 16);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        int tile;
        #12 rst_n = 1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        rd(0, v);  chk(v == 0, "R1 pixel zero after reset", v, 0);
        rd(16, v); chk(v == 0, "R1 tile zero after reset", v, 0);

        for (int p = 0; p < 6; p++) run_frame(p);

        // R8: unmapped address reads zero, tile address reads tile
        rd(20, v); chk(v == 0, "R8 unmapped address", v, 0);
        rd(31, v); chk(v == 0, "R8 top address", v, 0);

        // R7: inputs after window are ignored
        rd(16, tile);
        pix_bits = '1;
        repeat (20) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            rd(k, v);
            chk(v == exp_pix[k], "R7 pixel frozen", v, exp_pix[k]);
        end
        rd(16, v); chk(v == tile, "R7 tile frozen", v, tile);
        chk(done == 1'b1, "R7 done held", int'(done), 1);

        // R9: restart mid-window
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0; pix_bits = '1;
        repeat (50) @(negedge clk);
        rd(7, v); chk(v == 50, "R10 partial count before restart", v, 50);
        run_frame(0);
        rd(7, v);  chk(v == 0, "R9 restart clears pixel", v, 0);
        rd(16, v); chk(v == 0, "R9 restart clears tile", v, 0);

        // R2: start clears counts and done
        run_frame(1);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(done == 1'b0, "R2 done cleared by start", int'(done), 0);
        rd(16, v); chk(v == 0, "R2 tile cleared by start", v, 0);
        rd(9, v);  chk(v == 0, "R2 pixel cleared by start", v, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule